// File: doc/BRIEF.md
# Fast-Clock Strobe Divider Chain

This block turns one fast clock into a family of single-cycle clock-enable strobes for the processor core, the high-speed system bus, a peripheral reference, the low-speed peripheral bus and a secondary memory domain. Logic in each domain runs on the fast clock and advances only in cycles where its strobe is high, so no extra clock nets are needed. A single 32-bit control word holds the divider settings for the core, system bus and peripheral reference, and the system-bus to peripheral-bus ratio. A separate small divisor sets the memory strobe.

The core, system-bus and peripheral-reference dividers divide the fast clock by an even amount, or pass it straight through when their enable bit is clear. The peripheral-bus strobe and the memory strobe are derived from the system-bus strobe, so they always land on a system-bus strobe cycle. Two mask registers, one bit per attached peripheral, pass or block the bus strobe toward each peripheral's enable. Any write to the control word or to the memory divisor restarts every divider at once, so all strobes line up on a common edge after a change.

Top module: `clk_chain`

## Requirements
- R1: After reset, every divider is in pass-through (control word 0, memory divisor 0) and both mask registers are all ones, so all five strobes and every enable output are high in every cycle.
- R2: The core strobe divides the fast clock by 2*(F+1), where F is control bits 28:24, when control bit 30 is 1; when bit 30 is 0 it is high every cycle.
- R3: The system-bus strobe divides the fast clock by 2*(F+1), where F is control bits 20:16, when control bit 22 is 1; when bit 22 is 0 it is high every cycle.
- R4: The peripheral-reference strobe divides the fast clock by 2*(F+1), where F is control bits 12:8, when control bit 14 is 1; when bit 14 is 0 it is high every cycle.
- R5: The peripheral-bus strobe is high on every (R+1)-th system-bus strobe, where R is control bits 5:0, and is never high outside a system-bus strobe.
- R6: The memory strobe is high on every (M+1)-th system-bus strobe, where M is the 4-bit memory divisor, and is never high outside a system-bus strobe.
- R7: A write to the control word or to the memory divisor restarts all dividers: in the k-th cycle after the write edge (k counted from 0) a strobe with total period P is high exactly when (k+1) is a multiple of P; mask writes do not disturb strobe phase.
- R8: System-bus enable bit i is high exactly when system-bus mask bit i is 1 and the system-bus strobe is high (32 bits).
- R9: Peripheral-bus enable bit i is high exactly when peripheral-bus mask bit i is 1 and the peripheral-bus strobe is high (18 bits).
- R10: Control bits 31, 29, 23, 21, 15, 13, 7 and 6 have no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| mdiv_we | input | 1 | Memory divisor write strobe |
| mdiv_wdata | input | 4 | Memory divisor write data |
| ahb_mask_we | input | 1 | System-bus mask write strobe |
| ahb_mask_wdata | input | 32 | System-bus mask write data |
| apb_mask_we | input | 1 | Peripheral-bus mask write strobe |
| apb_mask_wdata | input | 18 | Peripheral-bus mask write data |
| cpu_stb | output | 1 | Core clock-enable strobe |
| ahb_stb | output | 1 | System-bus clock-enable strobe |
| per_stb | output | 1 | Peripheral-reference clock-enable strobe |
| apb_stb | output | 1 | Peripheral-bus clock-enable strobe |
| mem_stb | output | 1 | Memory-domain clock-enable strobe |
| ahb_en | output | 32 | Masked per-peripheral system-bus enables |
| apb_en | output | 18 | Masked per-peripheral peripheral-bus enables |

## Verification
The bench targets the divide-by-one versus divide-by-two boundary (field 0 with enable set must give period 2, and a set field with enable clear must give period 1), the largest settings where the peripheral-bus period reaches 4096 fast cycles, and the ratio and memory divisors counting system-bus strobes rather than fast cycles; a design that counted fast cycles would strobe off the bus edge. A restart triggered only by a memory-divisor write must realign the core strobe, and a mask write mid-stream must change enables without shifting phase; a design that reloaded counters on mask writes or missed the common restart would show strobes one or more cycles out of place. Control words with the unused bits set catch a decoder that reads the wrong field.

// File: rtl/clk_chain_pkg.sv
package clk_chain_pkg;

  localparam int DIV_W   = 5;
  localparam int RAT_W   = 6;
  localparam int CPU_LSB = 24;
  localparam int CPU_EN  = 30;
  localparam int AHB_LSB = 16;
  localparam int AHB_EN  = 22;
  localparam int PER_LSB = 8;
  localparam int PER_EN  = 14;
  localparam int RAT_LSB = 0;

  typedef struct packed {
    logic             cpu_on;
    logic [DIV_W-1:0] cpu_f;
    logic             ahb_on;
    logic [DIV_W-1:0] ahb_f;
    logic             per_on;
    logic [DIV_W-1:0] per_f;
    logic [RAT_W-1:0] ratio;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [31:0] w);
    ctl_t c;
    c.cpu_on = w[CPU_EN];
    c.cpu_f  = w[CPU_LSB +: DIV_W];
    c.ahb_on = w[AHB_EN];
    c.ahb_f  = w[AHB_LSB +: DIV_W];
    c.per_on = w[PER_EN];
    c.per_f  = w[PER_LSB +: DIV_W];
    c.ratio  = w[RAT_LSB +: RAT_W];
    return c;
  endfunction

endpackage

// File: rtl/clk_chain_div.sv
module clk_chain_div #(
  parameter int FW   = 5,
  parameter bit EVEN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          bypass,
  input  logic [FW-1:0] fld,
  input  logic          tick,
  output logic          stb
);
  localparam int CW = FW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] last;
  logic          hit;

  // terminal count: even variant ends at 2F+1, plain variant at F
  generate
    if (EVEN) begin : g_even
      assign last = {fld, 1'b1};
    end else begin : g_plain
      assign last = {1'b0, fld};
    end
  endgenerate

  assign hit = (cnt_q == last);
  assign stb = tick & (bypass | hit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick && !bypass) begin
      cnt_d = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/clk_chain_gate.sv
module clk_chain_gate #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  input  logic         stb,
  output logic [N-1:0] en
);
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we) begin
      mask_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      mask_q <= mask_d;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign en[i] = mask_q[i] & stb;
    end
  endgenerate
endmodule

// File: rtl/clk_chain.sv
module clk_chain
  import clk_chain_pkg::*;
#(
  parameter int AHB_N = 32,
  parameter int APB_N = 18,
  parameter int MEM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             mdiv_we,
  input  logic [MEM_W-1:0] mdiv_wdata,
  input  logic             ahb_mask_we,
  input  logic [AHB_N-1:0] ahb_mask_wdata,
  input  logic             apb_mask_we,
  input  logic [APB_N-1:0] apb_mask_wdata,
  output logic             cpu_stb,
  output logic             ahb_stb,
  output logic             per_stb,
  output logic             apb_stb,
  output logic             mem_stb,
  output logic [AHB_N-1:0] ahb_en,
  output logic [APB_N-1:0] apb_en
);
  localparam int SYNC_N = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rsync_q;
  logic              lrst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign lrst_n = rsync_q[SYNC_N-1];

  // configuration registers
  ctl_t             ctl_q, ctl_d;
  logic [MEM_W-1:0] mdiv_q, mdiv_d;
  logic             restart;

  always_comb begin
    ctl_d  = ctl_q;
    mdiv_d = mdiv_q;
    if (ctl_we) begin
      ctl_d = ctl_decode(ctl_wdata);
    end
    if (mdiv_we) begin
      mdiv_d = mdiv_wdata;
    end
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) begin
      ctl_q  <= '0;
      mdiv_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      mdiv_q <= mdiv_d;
    end
  end

  assign restart = ctl_we | mdiv_we;

  // fast-clock dividers
  clk_chain_div #(.FW(DIV_W), .EVEN(1'b1)) u_cpu (
    .clk(clk), .rst_n(lrst_n), .restart(restart), .bypass(!ctl_q.cpu_on),
    .fld(ctl_q.cpu_f), .tick(1'b1), .stb(cpu_stb));

  clk_chain_div #(.FW(DIV_W), .EVEN(1'b1)) u_ahb (
    .clk(clk), .rst_n(lrst_n), .restart(restart), .bypass(!ctl_q.ahb_on),
    .fld(ctl_q.ahb_f), .tick(1'b1), .stb(ahb_stb));

  clk_chain_div #(.FW(DIV_W), .EVEN(1'b1)) u_per (
    .clk(clk), .rst_n(lrst_n), .restart(restart), .bypass(!ctl_q.per_on),
    .fld(ctl_q.per_f), .tick(1'b1), .stb(per_stb));

  // bus-strobe dividers: count system-bus strobes only
  clk_chain_div #(.FW(RAT_W), .EVEN(1'b0)) u_apb (
    .clk(clk), .rst_n(lrst_n), .restart(restart), .bypass(1'b0),
    .fld(ctl_q.ratio), .tick(ahb_stb), .stb(apb_stb));

  clk_chain_div #(.FW(MEM_W), .EVEN(1'b0)) u_mem (
    .clk(clk), .rst_n(lrst_n), .restart(restart), .bypass(1'b0),
    .fld(mdiv_q), .tick(ahb_stb), .stb(mem_stb));

  // per-peripheral masks
  clk_chain_gate #(.N(AHB_N)) u_ahb_gate (
    .clk(clk), .rst_n(lrst_n), .we(ahb_mask_we), .wdata(ahb_mask_wdata),
    .stb(ahb_stb), .en(ahb_en));

  clk_chain_gate #(.N(APB_N)) u_apb_gate (
    .clk(clk), .rst_n(lrst_n), .we(apb_mask_we), .wdata(apb_mask_wdata),
    .stb(apb_stb), .en(apb_en));
endmodule

// File: rtl/clk_chain_chk.sv
module clk_chain_chk #(
  parameter int AHB_N = 32,
  parameter int APB_N = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [31:0]      ctl_wdata,
  input logic             cpu_stb,
  input logic             ahb_stb,
  input logic             apb_stb,
  input logic             mem_stb,
  input logic [AHB_N-1:0] ahb_en,
  input logic [APB_N-1:0] apb_en
);
  // R5
  apb_on_ahb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apb_stb |-> ahb_stb);

  // R6
  mem_on_ahb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb |-> ahb_stb);

  // R8
  ahb_en_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ahb_en) |-> ahb_stb);

  // R9
  apb_en_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|apb_en) |-> apb_stb);

  // R2
  cpu_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[30]) |=> cpu_stb);

  // R7
  cpu_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[30]) |=> !cpu_stb);
endmodule

bind clk_chain clk_chain_chk #(.AHB_N(AHB_N), .APB_N(APB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .cpu_stb(cpu_stb), .ahb_stb(ahb_stb), .apb_stb(apb_stb), .mem_stb(mem_stb),
  .ahb_en(ahb_en), .apb_en(apb_en));

// File: tb/clk_chain_test.sv
module clk_chain_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        mdiv_we = 1'b0;
  logic [3:0]  mdiv_wdata = '0;
  logic        ahb_mask_we = 1'b0;
  logic [31:0] ahb_mask_wdata = '0;
  logic        apb_mask_we = 1'b0;
  logic [17:0] apb_mask_wdata = '0;
  logic        cpu_stb, ahb_stb, per_stb, apb_stb, mem_stb;
  logic [31:0] ahb_en;
  logic [17:0] apb_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  clk_chain uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mdiv_we(mdiv_we), .mdiv_wdata(mdiv_wdata),
    .ahb_mask_we(ahb_mask_we), .ahb_mask_wdata(ahb_mask_wdata),
    .apb_mask_we(apb_mask_we), .apb_mask_wdata(apb_mask_wdata),
    .cpu_stb(cpu_stb), .ahb_stb(ahb_stb), .per_stb(per_stb),
    .apb_stb(apb_stb), .mem_stb(mem_stb), .ahb_en(ahb_en), .apb_en(apb_en));

  // columns: control word, memory divisor, periods of cpu, ahb, per, apb, mem
  localparam logic [31:0] VEC [0:4][0:6] = '{
    '{32'h0000_0000, 32'd0,  32'd1,  32'd1,  32'd1,  32'd1,    32'd1},
    '{32'h4041_4201, 32'd2,  32'd2,  32'd4,  32'd6,  32'd8,    32'd12},
    '{32'hC385_8004, 32'd0,  32'd8,  32'd1,  32'd1,  32'd5,    32'd1},
    '{32'h0740_4002, 32'd3,  32'd1,  32'd2,  32'd2,  32'd6,    32'd8},
    '{32'h5F5F_5F3F, 32'd15, 32'd64, 32'd64, 32'd64, 32'd4096, 32'd1024}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hi(input int k, input int p);
    return ((k + 1) % p) == 0;
  endfunction

  // write config; returns at the negedge of cycle k=0
  task automatic put_cfg(input logic [31:0] c, input logic [3:0] m);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = c; mdiv_we = 1'b1; mdiv_wdata = m;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0; mdiv_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad_s, bad_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    bad_s = 0; bad_e = 0;
    for (int k = 0; k < 8; k++) begin
      if ({cpu_stb, ahb_stb, per_stb, apb_stb, mem_stb} != 5'b11111) bad_s++;
      if (ahb_en != '1 || apb_en != '1) bad_e++;
      @(negedge clk);
    end
    check(bad_s == 0, "R1 strobes after reset", bad_s, 0);
    check(bad_e == 0, "R1 enables after reset", bad_e, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < 5; v++) begin
      int pc, pa, pp, pb, pm, len;
      int ec, ea, ep, eb, em;
      pc = VEC[v][2]; pa = VEC[v][3]; pp = VEC[v][4]; pb = VEC[v][5]; pm = VEC[v][6];
      len = 2 * ((pb > pm) ? pb : pm) + 2 * pc + 2 * pp + 4;
      ec = 0; ea = 0; ep = 0; eb = 0; em = 0;
      put_cfg(VEC[v][0], VEC[v][1][3:0]);
      for (int k = 0; k < len; k++) begin
        if (cpu_stb !== hi(k, pc)) ec++;
        if (ahb_stb !== hi(k, pa)) ea++;
        if (per_stb !== hi(k, pp)) ep++;
        if (apb_stb !== hi(k, pb)) eb++;
        if (mem_stb !== hi(k, pm)) em++;
        @(negedge clk);
      end
      $display("vector %0d (R7 restart phase, R10 unused bits in vector 2)", v);
      check(ec == 0, "R2 cpu period", ec, 0);
      check(ea == 0, "R3 ahb period", ea, 0);
      check(ep == 0, "R4 per period", ep, 0);
      check(eb == 0, "R5 apb ratio", eb, 0);
      check(em == 0, "R6 mem divisor", em, 0);
    end

    // R8 R9 masks, and R7 mask write keeps phase
    begin
      logic [31:0] ga;
      logic [17:0] gb;
      int e8, e9, e7;
      ga = '1; gb = '1; e8 = 0; e9 = 0; e7 = 0;
      put_cfg(32'h4041_4201, 4'd2);
      for (int k = 0; k < 40; k++) begin
        if (k == 6) begin
          ahb_mask_we = 1'b0; apb_mask_we = 1'b0;
          ga = 32'hA5A5_0F0F; gb = 18'h2_AAAA;
        end
        if (ahb_en !== (hi(k, 4) ? ga : 32'h0)) e8++;
        if (apb_en !== (hi(k, 8) ? gb : 18'h0)) e9++;
        if (cpu_stb !== hi(k, 2) || ahb_stb !== hi(k, 4)) e7++;
        if (k == 5) begin
          ahb_mask_we = 1'b1; ahb_mask_wdata = 32'hA5A5_0F0F;
          apb_mask_we = 1'b1; apb_mask_wdata = 18'h2_AAAA;
        end
        @(negedge clk);
      end
      check(e8 == 0, "R8 ahb mask", e8, 0);
      check(e9 == 0, "R9 apb mask", e9, 0);
      check(e7 == 0, "R7 mask write keeps phase", e7, 0);
    end

    // R7 memory-divisor write alone realigns every divider
    begin
      int e7;
      e7 = 0;
      put_cfg(32'h4041_4201, 4'd2);
      for (int k = 0; k < 3; k++) begin
        if (cpu_stb !== hi(k, 2)) e7++;
        if (k < 2) @(negedge clk);
      end
      mdiv_we = 1'b1; mdiv_wdata = 4'd2;
      @(posedge clk);
      @(negedge clk);
      mdiv_we = 1'b0;
      for (int k = 0; k < 30; k++) begin
        if (cpu_stb !== hi(k, 2) || ahb_stb !== hi(k, 4) ||
            mem_stb !== hi(k, 12) || per_stb !== hi(k, 6)) e7++;
        @(negedge clk);
      end
      check(e7 == 0, "R7 memory divisor write restart", e7, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule